// File: doc/BRIEF.md
# Pipelined Integer Divider with Per-Operand Signedness

This block divides a numerator by a denominator and returns a quotient as wide as the numerator and a remainder as wide as the denominator. Each operand is independently configured as unsigned or two's complement signed. The division is a chain of one-bit restoring steps, one per numerator bit. A latency parameter places between zero and numerator-width register ranks along that chain, so the same block serves as a purely combinational divider or as a pipeline that accepts a new operation on every enabled cycle.

Two remainder conventions are available. In the default one, the quotient is truncated toward zero and the remainder carries the numerator's sign. In the other one, the remainder is never negative and the quotient shifts by one step to keep the division identity true. A zero divisor gives a fixed, documented result and raises no flag.

The pipeline ranks load only while the clock enable is high. An active-high asynchronous clear empties them at any moment.

Top module: `intdiv_top`

## Requirements
- R1: The quotient is NUM_W bits and the remainder is DEN_W bits. The numerator is read as two's complement when NUM_SIGNED is 1 and as unsigned otherwise. The denominator follows DEN_SIGNED in the same way, independently of the numerator.
- R2: With POS_REM = 0 and a non-zero divisor, the quotient is the true quotient truncated toward zero. The remainder is zero or has the sign of the numerator. Both are taken modulo 2 to the power of their widths.
- R3: For any non-zero divisor, the remainder magnitude is below the divisor magnitude, and quotient times denominator plus remainder equals the numerator modulo 2^NUM_W.
- R4: With POS_REM = 1 and a non-zero divisor, the remainder lies in the range 0 to |denominator| - 1. Whenever the truncated remainder would be negative, |denominator| is added to it. The quotient then drops by one for a positive divisor and rises by one for a negative divisor.
- R5: A zero denominator gives a quotient of all ones. The remainder is the numerator resized to DEN_W bits: sign-extended if the numerator is signed, zero-extended if it is unsigned, and truncated if DEN_W is narrower. This rule overrides R2 and R4.
- R6: The result of an operation appears LATENCY enabled clock edges after its operands are presented, and a new operation may be presented at every edge. LATENCY = 0 makes the outputs combinational. LATENCY must lie between 0 and NUM_W, and NUM_W and DEN_W must each be at least 2; any other value stops elaboration.
- R7: While clken is low, no pipeline rank changes, so registered outputs hold their values whatever the operand inputs do.
- R8: Raising aclr immediately zeroes every pipeline rank. With LATENCY of at least 1, both outputs then read zero until new operations emerge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the pipeline ranks |
| aclr | input | 1 | Asynchronous clear, active high, zeroes all ranks |
| clken | input | 1 | Rank load enable; tie high when unused |
| num_i | input | NUM_W | Numerator |
| den_i | input | DEN_W | Denominator |
| quo_o | output | NUM_W | Quotient |
| rem_o | output | DEN_W | Remainder |

## Verification
The assertions assume that clken and aclr are never unknown. They also assume that aclr is released between clock edges, so that the first enabled cycle afterwards still shows the cleared ranks. The remainder-bound and non-negative-remainder properties are keyed on a non-zero divisor magnitude carried down the pipe. This keeps them quiet for cleared ranks and for zero divisors. The stimulus changes operands and control only one time unit after a rising edge. It holds aclr across the first edges and keeps each operand pair steady long enough for the deepest instance before it samples.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

   // True when a register rank follows quotient-bit step 'step' for a chain
   // of 'width' steps carrying 'lat' ranks. The ranks are spread evenly and
   // the last rank always follows the final step.
   function automatic bit stage_reg_after(input int step, input int lat, input int width);
      return (((step + 1) * lat) / width) != ((step * lat) / width);
   endfunction

endpackage

// File: rtl/intdiv_front.sv
module intdiv_front #(
   parameter int NUM_W      = 16,
   parameter int DEN_W      = 16,
   parameter bit NUM_SIGNED = 1'b1,
   parameter bit DEN_SIGNED = 1'b1
) (
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic [NUM_W-1:0] nmag_o,
   output logic [DEN_W-1:0] dmag_o,
   output logic [DEN_W-1:0] nlo_o,
   output logic             n_neg_o,
   output logic             d_neg_o,
   output logic             dz_o
);

   assign n_neg_o = NUM_SIGNED & num_i[NUM_W-1];
   assign d_neg_o = DEN_SIGNED & den_i[DEN_W-1];

   // Magnitudes fit unsigned in the operand width (the most negative value included)
   assign nmag_o = n_neg_o ? (NUM_W'(0) - num_i) : num_i;
   assign dmag_o = d_neg_o ? (DEN_W'(0) - den_i) : den_i;
   assign dz_o   = (den_i == '0);

   // Numerator resized to remainder width, used for the zero-divisor result (R5)
   if (DEN_W > NUM_W) begin : g_ext
      assign nlo_o = {{(DEN_W - NUM_W){n_neg_o}}, num_i};
   end else begin : g_cut
      assign nlo_o = num_i[DEN_W-1:0];
   end

endmodule

// File: rtl/intdiv_step.sv
module intdiv_step #(
   parameter int NUM_W = 16,
   parameter int DEN_W = 16,
   localparam int REM_W = DEN_W + 1
) (
   input  logic [REM_W-1:0] rem_i,
   input  logic [NUM_W-1:0] qn_i,
   input  logic [DEN_W-1:0] dmag_i,
   output logic [REM_W-1:0] rem_o,
   output logic [NUM_W-1:0] qn_o
);

   logic [REM_W:0] trial;
   logic [REM_W:0] diff;
   logic           fits;

   // Shift the next numerator bit into the partial remainder and try a subtraction
   assign trial = {rem_i, qn_i[NUM_W-1]};
   assign diff  = trial - {2'b00, dmag_i};
   assign fits  = ~diff[REM_W];

   assign rem_o = fits ? diff[REM_W-1:0] : trial[REM_W-1:0];
   assign qn_o  = {qn_i[NUM_W-2:0], fits};

endmodule

// File: rtl/intdiv_back.sv
module intdiv_back #(
   parameter int NUM_W      = 16,
   parameter int DEN_W      = 16,
   parameter bit DEN_SIGNED = 1'b1,
   parameter bit POS_REM    = 1'b0,
   localparam int REM_W = DEN_W + 1
) (
   input  logic             clk,
   input  logic             aclr,
   input  logic [NUM_W-1:0] qmag_i,
   input  logic [REM_W-1:0] rwide_i,
   input  logic [DEN_W-1:0] dmag_i,
   input  logic [DEN_W-1:0] nlo_i,
   input  logic             n_neg_i,
   input  logic             d_neg_i,
   input  logic             dz_i,
   output logic [NUM_W-1:0] quo_o,
   output logic [DEN_W-1:0] rem_o
);

   logic [DEN_W-1:0] rmag;
   logic [NUM_W-1:0] q_t;
   logic [DEN_W-1:0] r_t;
   logic [NUM_W-1:0] q_f;
   logic [DEN_W-1:0] r_f;

   assign rmag = rwide_i[DEN_W-1:0];
   assign q_t  = (n_neg_i ^ d_neg_i) ? (NUM_W'(0) - qmag_i) : qmag_i;
   assign r_t  = n_neg_i ? (DEN_W'(0) - rmag) : rmag;

   if (POS_REM) begin : g_floor
      logic lift;
      assign lift = n_neg_i && (rmag != '0);
      assign r_f  = lift ? (dmag_i - rmag) : r_t;
      assign q_f  = !lift ? q_t : (d_neg_i ? (q_t + 1'b1) : (q_t - 1'b1));
   end else begin : g_trunc
      assign r_f = r_t;
      assign q_f = q_t;
   end

   assign quo_o = dz_i ? '1 : q_f;
   assign rem_o = dz_i ? nlo_i : r_f;

   // R3: the magnitude leaving the divide chain is below the divisor magnitude
   p_rem_below_r3 : assert property (@(posedge clk) disable iff (aclr)
      (dmag_i != '0) |-> (rwide_i < {1'b0, dmag_i}));

   if (POS_REM && DEN_SIGNED) begin : g_chk_pos
      // R4: a signed remainder in the non-negative convention never has its sign bit set
      p_posrem_r4 : assert property (@(posedge clk) disable iff (aclr)
         (dmag_i != '0) |-> !rem_o[DEN_W-1]);
   end

endmodule

// File: rtl/intdiv_top.sv
module intdiv_top #(
   parameter int NUM_W      = 16,
   parameter int DEN_W      = 16,
   parameter bit NUM_SIGNED = 1'b1,
   parameter bit DEN_SIGNED = 1'b1,
   parameter bit POS_REM    = 1'b0,
   parameter int LATENCY    = 4
) (
   input  logic             clk,
   input  logic             aclr,
   input  logic             clken,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic [NUM_W-1:0] quo_o,
   output logic [DEN_W-1:0] rem_o
);
   import intdiv_pkg::*;

   localparam int REM_W = DEN_W + 1;

   if (LATENCY < 0 || LATENCY > NUM_W || NUM_W < 2 || DEN_W < 2) begin : g_bad_cfg
      $error("intdiv_top: LATENCY must be 0..NUM_W and both widths at least 2");
   end

   typedef struct packed {
      logic [REM_W-1:0] rem;
      logic [NUM_W-1:0] qn;
      logic [DEN_W-1:0] dmag;
      logic [DEN_W-1:0] nlo;
      logic             n_neg;
      logic             d_neg;
      logic             dz;
   } st_t;

   logic [NUM_W-1:0] f_nmag;
   logic [DEN_W-1:0] f_dmag;
   logic [DEN_W-1:0] f_nlo;
   logic             f_nneg;
   logic             f_dneg;
   logic             f_dz;
   st_t              s_front;
   st_t              s_last;

   intdiv_front #(
      .NUM_W(NUM_W), .DEN_W(DEN_W),
      .NUM_SIGNED(NUM_SIGNED), .DEN_SIGNED(DEN_SIGNED)
   ) u_front (
      .num_i(num_i), .den_i(den_i),
      .nmag_o(f_nmag), .dmag_o(f_dmag), .nlo_o(f_nlo),
      .n_neg_o(f_nneg), .d_neg_o(f_dneg), .dz_o(f_dz)
   );

   assign s_front = '{rem: '0, qn: f_nmag, dmag: f_dmag, nlo: f_nlo,
                      n_neg: f_nneg, d_neg: f_dneg, dz: f_dz};

   for (genvar i = 0; i < NUM_W; i++) begin : g_step
      st_t              s_in;
      st_t              s_cmb;
      st_t              s_nx;
      logic [REM_W-1:0] rem_w;
      logic [NUM_W-1:0] qn_w;

      if (i == 0) begin : g_first
         assign s_in = s_front;
      end else begin : g_link
         assign s_in = g_step[i-1].s_nx;
      end

      intdiv_step #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_step (
         .rem_i(s_in.rem), .qn_i(s_in.qn), .dmag_i(s_in.dmag),
         .rem_o(rem_w), .qn_o(qn_w)
      );

      assign s_cmb = '{rem: rem_w, qn: qn_w, dmag: s_in.dmag, nlo: s_in.nlo,
                       n_neg: s_in.n_neg, d_neg: s_in.d_neg, dz: s_in.dz};

      if (stage_reg_after(i, LATENCY, NUM_W)) begin : g_reg
         st_t s_q;
         always_ff @(posedge clk or posedge aclr) begin
            if (aclr)       s_q <= '0;
            else if (clken) s_q <= s_cmb;
         end
         assign s_nx = s_q;
      end else begin : g_wire
         assign s_nx = s_cmb;
      end
   end

   assign s_last = g_step[NUM_W-1].s_nx;

   intdiv_back #(
      .NUM_W(NUM_W), .DEN_W(DEN_W),
      .DEN_SIGNED(DEN_SIGNED), .POS_REM(POS_REM)
   ) u_back (
      .clk(clk), .aclr(aclr),
      .qmag_i(s_last.qn), .rwide_i(s_last.rem), .dmag_i(s_last.dmag),
      .nlo_i(s_last.nlo), .n_neg_i(s_last.n_neg), .d_neg_i(s_last.d_neg),
      .dz_i(s_last.dz),
      .quo_o(quo_o), .rem_o(rem_o)
   );

   if (LATENCY > 0) begin : g_chk_reg
      // R7: a cycle with the enable low leaves the registered results untouched
      p_hold_r7 : assert property (@(posedge clk) disable iff (aclr)
         !clken |=> ($stable(quo_o) && $stable(rem_o)));

      // R8: on the first edge after the clear is released the outputs are still zero
      p_clear_r8 : assert property (@(posedge clk) disable iff (aclr)
         $fell(aclr) |-> ((quo_o == '0) && (rem_o == '0)));
   end

endmodule

// File: tb/test_intdiv_top.sv
module test_intdiv_top;

   localparam int W     = 8;
   localparam int NVEC  = 15;
   localparam int LAT_A = 3;

   logic         clk = 1'b0;
   logic         aclr = 1'b1;
   logic         clken = 1'b1;
   logic [W-1:0] num = '0;
   logic [W-1:0] den = 8'd1;
   logic [W-1:0] qa, ra, qb, rb, qc, rc;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   always #5 clk = ~clk;

   // A: signed/signed, truncating, 3 ranks
   intdiv_top #(.NUM_W(W), .DEN_W(W), .NUM_SIGNED(1'b1), .DEN_SIGNED(1'b1),
                .POS_REM(1'b0), .LATENCY(LAT_A)) i_intdiv_top (
      .clk(clk), .aclr(aclr), .clken(clken), .num_i(num), .den_i(den),
      .quo_o(qa), .rem_o(ra));

   // B: signed/signed, non-negative remainder, maximum latency
   intdiv_top #(.NUM_W(W), .DEN_W(W), .NUM_SIGNED(1'b1), .DEN_SIGNED(1'b1),
                .POS_REM(1'b1), .LATENCY(W)) i_intdiv_top_pos (
      .clk(clk), .aclr(aclr), .clken(clken), .num_i(num), .den_i(den),
      .quo_o(qb), .rem_o(rb));

   // C: unsigned numerator, signed denominator, combinational
   intdiv_top #(.NUM_W(W), .DEN_W(W), .NUM_SIGNED(1'b0), .DEN_SIGNED(1'b1),
                .POS_REM(1'b0), .LATENCY(0)) i_intdiv_top_mix (
      .clk(clk), .aclr(aclr), .clken(clken), .num_i(num), .den_i(den),
      .quo_o(qc), .rem_o(rc));

   // {numerator, denominator}
   localparam logic [15:0] VEC [NVEC] = '{
      16'h64_07, 16'h9C_07, 16'h64_F9, 16'h9C_F9, 16'h80_FF,
      16'h80_01, 16'h7F_80, 16'h00_05, 16'h05_00, 16'hFB_00,
      16'hC8_03, 16'h07_09, 16'hF9_09, 16'hFF_FF, 16'h80_80};

   function automatic logic [15:0] ref_div(logic [7:0] n, logic [7:0] d,
                                           bit ns, bit ds, bit pos);
      int nv, dv, q, r;
      nv = ns ? int'($signed(n)) : int'(n);
      dv = ds ? int'($signed(d)) : int'(d);
      if (dv == 0) return {8'hFF, n};
      q = nv / dv;
      r = nv % dv;
      if (pos && r < 0) begin
         r = r + ((dv < 0) ? -dv : dv);
         q = q + ((dv < 0) ? 1 : -1);
      end
      return {q[7:0], r[7:0]};
   endfunction

   task automatic chk(string req, string who, logic [15:0] got, logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got q=%h r=%h expected q=%h r=%h",
                  req, who, got[15:8], got[7:0], exp[15:8], exp[7:0]);
      end
   endtask

   // R3 checked from the observed outputs alone, without the reference model
   task automatic chk_identity(logic [7:0] n, logic [7:0] d, logic [7:0] q, logic [7:0] r);
      int qv, rv, dv, prod;
      qv = int'($signed(q));
      rv = int'($signed(r));
      dv = int'($signed(d));
      prod = qv * dv + rv;
      checks++;
      if (prod[7:0] !== n || ((rv < 0) ? -rv : rv) >= ((dv < 0) ? -dv : dv)) begin
         fails++;
         $display("FAIL R3: n=%h d=%h got q=%h r=%h expected q*d+r=%h and |r|<|d|",
                  n, d, q, r, n);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] v;
      #2;
      // R8: registered instances read zero while cleared
      chk("R8", "reset A", {qa, ra}, 16'h0000);
      chk("R8", "reset B", {qb, rb}, 16'h0000);
      chk("R1", "reset C", {qc, rc}, ref_div(8'h00, 8'h01, 1'b0, 1'b1, 1'b0));
      @(posedge clk); #1 aclr = 1'b0;

      // Vector table
      for (int i = 0; i < NVEC; i++) begin
         @(posedge clk); #1;
         {num, den} = VEC[i];
         repeat (W + 1) @(posedge clk);
         #2;
         if (den == 8'h00) begin
            chk("R5", "div0 A", {qa, ra}, ref_div(num, den, 1'b1, 1'b1, 1'b0));
            chk("R5", "div0 B", {qb, rb}, ref_div(num, den, 1'b1, 1'b1, 1'b1));
            chk("R5", "div0 C", {qc, rc}, ref_div(num, den, 1'b0, 1'b1, 1'b0));
         end else begin
            chk("R2", "trunc A", {qa, ra}, ref_div(num, den, 1'b1, 1'b1, 1'b0));
            chk("R4", "posrem B", {qb, rb}, ref_div(num, den, 1'b1, 1'b1, 1'b1));
            chk("R1", "mixed C", {qc, rc}, ref_div(num, den, 1'b0, 1'b1, 1'b0));
            chk_identity(num, den, qa, ra);
         end
      end

      // R6: back-to-back operations, A exactly LAT_A edges behind, C same cycle
      for (int j = 0; j < NVEC + LAT_A; j++) begin
         @(posedge clk); #1;
         if (j < NVEC) {num, den} = VEC[j];
         #1;
         if (j < NVEC) begin
            v = VEC[j];
            chk("R6", "comb C", {qc, rc}, ref_div(v[15:8], v[7:0], 1'b0, 1'b1, 1'b0));
         end
         if (j >= LAT_A) begin
            v = VEC[j-LAT_A];
            chk("R6", "pipe A", {qa, ra}, ref_div(v[15:8], v[7:0], 1'b1, 1'b1, 1'b0));
         end
      end

      // R7: enable low freezes the registered results
      @(posedge clk); #1;
      {num, den} = VEC[0];
      repeat (W + 1) @(posedge clk);
      #1;
      clken = 1'b0;
      {num, den} = VEC[3];
      repeat (W + 2) @(posedge clk);
      #2;
      v = VEC[0];
      chk("R7", "hold A", {qa, ra}, ref_div(v[15:8], v[7:0], 1'b1, 1'b1, 1'b0));
      chk("R7", "hold B", {qb, rb}, ref_div(v[15:8], v[7:0], 1'b1, 1'b1, 1'b1));
      @(posedge clk); #1 clken = 1'b1;
      repeat (W + 1) @(posedge clk);
      #2;
      v = VEC[3];
      chk("R7", "resume A", {qa, ra}, ref_div(v[15:8], v[7:0], 1'b1, 1'b1, 1'b0));
      chk("R7", "resume B", {qb, rb}, ref_div(v[15:8], v[7:0], 1'b1, 1'b1, 1'b1));

      // R8: asynchronous clear between edges
      @(posedge clk); #1 aclr = 1'b1;
      #2;
      chk("R8", "clear A", {qa, ra}, 16'h0000);
      chk("R8", "clear B", {qb, rb}, 16'h0000);
      chk("R8", "clear C", {qc, rc}, ref_div(v[15:8], v[7:0], 1'b0, 1'b1, 1'b0));
      @(posedge clk); #1 aclr = 1'b0;
      repeat (W + 1) @(posedge clk);
      #2;
      chk("R8", "refill A", {qa, ra}, ref_div(v[15:8], v[7:0], 1'b1, 1'b1, 1'b0));
      chk("R8", "refill B", {qb, rb}, ref_div(v[15:8], v[7:0], 1'b1, 1'b1, 1'b1));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule